// File: doc/BRIEF.md
# Serial Boot Controller with Reset Sequencing

This block loads a program image into system memory from a host serial link while the processor core is held in reset. It drives two reset outputs: one for the memory subsystem, one for the core. A pushbutton reset or a load request drives both low. After a fixed hold time the memory side is released, so the memory controller runs while the core stays stopped. The loader then parses byte commands from an already-decoded UART receive stream. It writes incoming data into memory as packed words, zero-fills ranges for uninitialised data, and finally starts the core at an entry address supplied by the host.

Each command begins with a one-byte opcode and a 32-bit little-endian address. Fill and zero commands then carry a 32-bit little-endian byte count. Every finished command is answered with one byte on a transmit stream. After the start command the loader gives up the memory port and drops every further received byte. A build option starts the core straight away at a default address, for images that are already in memory.

Top module: `serial_boot_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `load_req` is seen high, `mem_rst_n` and `core_rst_n` are both 0 and `boot_addr` returns to BOOT_DEFAULT (0 by default).
- R2: `mem_rst_n` rises exactly HOLD_CYC (default 4) clock edges after a restart ends, while `core_rst_n` stays 0.
- R3: `core_rst_n` stays 0 through every fill, zero and rejected command, and rises only after the start command is acknowledged.
- R4: Opcode 0x01 (fill) is followed by a 4-byte little-endian address A, a 4-byte little-endian length N and N data bytes. Data byte i lands at byte address A+i, in byte lane (A+i) mod 4 of the 32-bit word at that aligned address, with one memory transaction per word. N = 0 gives an acknowledge and no memory transaction.
- R5: A word that is only partly covered, at an unaligned start or at the tail of a range, is written with only the covered byte enables set; the other bytes of that word keep their contents.
- R6: Opcode 0x02 (zero) takes an address and a length like R4 and writes zeros over exactly that byte range, with partial enables at the ends. With `mem_ready` held high its transactions follow on consecutive cycles.
- R7: A fill or zero command is answered with 0x06 once its last memory write is accepted. Any opcode other than 0x01, 0x02 or 0x03 is answered with 0x15, and the next byte is read as a new opcode.
- R8: Opcode 0x03 (start) is followed by a 4-byte little-endian address E. After its 0x06 answer is taken, `core_rst_n` goes to 1 and `boot_addr` equals E.
- R9: After the start, received bytes cause no memory transaction and no answer byte. The memory port is driven only while the memory side is out of reset and the core is in reset.
- R10: A `load_req` pulse in the middle of a transfer aborts it. From the next cycle `mem_req` is 0 and both resets are asserted. Once the memory reset releases again, a new load works normally.
- R11: Pulling `rst_n` low after the core has started puts the core back into reset and restarts the whole sequence.
- R12: With PRELOADED set, the core is released with `boot_addr` = BOOT_DEFAULT once the hold time ends, without any command.
- R13: A memory request that is not accepted holds its address, data and byte enables until `mem_ready` is high. An answer byte holds until `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Pushbutton reset, synchronous, active low |
| load_req | input | 1 | Restart request from the host side, one cycle wide |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Loader takes the byte this cycle |
| tx_data | output | 8 | Answer byte (0x06 done, 0x15 rejected) |
| tx_valid | output | 1 | Answer byte present |
| tx_ready | input | 1 | Transmitter takes the answer byte |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | DATA_W | Write word, byte lane k at bits 8k+7..8k |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rst_n | output | 1 | Reset to the memory subsystem, active low |
| core_rst_n | output | 1 | Reset to the processor core, active low |
| boot_addr | output | 32 | Address the core starts from |

## Verification
The in-line properties watch, on every cycle, the ordering of the two resets and the forced reset after a load request. They also check that the memory port is used only inside the load window, that stalled requests and answer bytes stay stable, and that every request carries at least one byte enable. What lands in memory is shown only by the bench scenarios: lane placement, partial-word enables, exact zero-fill bounds, the acknowledge codes, the gap-free zero burst, the start address, the drop of bytes after start, the abort mid-burst, and the preloaded start.

// File: rtl/boot_pkg.sv
// Shared encodings of the serial boot controller.
// Assumes single-byte opcodes followed by little-endian 32-bit fields.
package boot_pkg;
    localparam logic [7:0] OP_FILL  = 8'h01;
    localparam logic [7:0] OP_ZERO  = 8'h02;
    localparam logic [7:0] OP_START = 8'h03;
    localparam logic [7:0] RSP_OK   = 8'h06;
    localparam logic [7:0] RSP_BAD  = 8'h15;

    typedef enum logic [3:0] {
        LD_HOLD,   // waiting for memory reset release
        LD_OP,     // expecting an opcode byte
        LD_ADDR,   // collecting address bytes
        LD_LEN,    // collecting length bytes
        LD_DATA,   // packing data bytes into a word
        LD_WR,     // presenting a packed word
        LD_ZERO,   // presenting zero words
        LD_RSP,    // presenting the answer byte
        LD_RUN     // core running, input dropped
    } ld_state_e;
endpackage

// File: rtl/boot_rst_seq.sv
// Reset sequencer: drives the memory and core resets and holds the boot address.
// Assumes rst_n and load_req are synchronous to clk; boot_go is a one-cycle pulse.
module boot_rst_seq #(
    parameter int          HOLD_CYC     = 4,
    parameter logic [31:0] BOOT_DEFAULT = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_req,
    input  logic        boot_go,
    input  logic [31:0] go_addr,
    output logic        mem_rst_n,
    output logic        core_rst_n,
    output logic        mem_up,
    output logic [31:0] boot_addr
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic [CW-1:0] hold_cnt;

    // Restart forces both resets; memory released after the hold, core on boot_go.
    always_ff @(posedge clk) begin
        if (!rst_n || load_req) begin
            hold_cnt   <= '0;
            mem_rst_n  <= 1'b0;
            core_rst_n <= 1'b0;
            boot_addr  <= BOOT_DEFAULT;
        end else begin
            if (!mem_rst_n) begin
                if (hold_cnt == CW'(HOLD_CYC - 1)) mem_rst_n <= 1'b1;
                else                               hold_cnt  <= hold_cnt + 1'b1;
            end
            if (boot_go) begin
                core_rst_n <= 1'b1;
                boot_addr  <= go_addr;
            end
        end
    end

    // Loader window: memory alive, core stopped.
    assign mem_up = mem_rst_n && !core_rst_n;

    // R2
    core_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n |-> mem_rst_n);
    // R10
    restart_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (!mem_rst_n && !core_rst_n));
    // R8
    core_release_chk: assert property (@(posedge clk) disable iff (!rst_n || load_req)
        $rose(core_rst_n) |-> $past(boot_go));
endmodule

// File: rtl/boot_cmd_fsm.sv
// Command parser and memory writer of the serial boot controller.
// Parses opcode/address/length/data bytes, packs bytes into words with byte
// enables, zero-fills ranges and sends one answer byte per command.
// Assumes DATA_W is a power-of-two multiple of 16 bits.
module boot_cmd_fsm
    import boot_pkg::*;
#(
    parameter int          DATA_W       = 32,
    parameter logic [31:0] BOOT_DEFAULT = 32'h0,
    parameter bit          PRELOADED    = 1'b0,
    localparam int         NB           = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              mem_up,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NB-1:0]     mem_be,
    input  logic              mem_ready,
    output logic              boot_go,
    output logic [31:0]       go_addr
);
    localparam int LW = $clog2(NB);

    ld_state_e         state;
    logic [7:0]        op;
    logic [1:0]        fcnt;
    logic [31:0]       cur, rem, waddr;
    logic [DATA_W-1:0] wbuf;
    logic [NB-1:0]     wbe, zero_be;
    logic [7:0]        rsp;
    logic              to_run;
    logic              rx_take;
    logic [LW-1:0]     lane;
    logic [31:0]       addr_next, len_next, zero_n, lane_room;
    logic [31:0]       cur_word;

    assign lane      = cur[LW-1:0];
    assign addr_next = {rx_data, cur[31:8]};
    assign len_next  = {rx_data, rem[31:8]};
    assign cur_word  = {cur[31:LW], {LW{1'b0}}};
    assign rx_take   = rx_valid && rx_ready;

    // Bytes covered by the next zero word and their enables.
    always_comb begin
        lane_room = 32'(NB) - 32'(lane);
        zero_n    = (rem < lane_room) ? rem : lane_room;
        for (int i = 0; i < NB; i++) begin
            zero_be[i] = (32'(i) >= 32'(lane)) && (32'(i) < 32'(lane) + zero_n);
        end
    end

    // Command state machine with address, length and word packing registers.
    always_ff @(posedge clk) begin
        if (!rst_n || load_req) begin
            state  <= LD_HOLD;
            op     <= '0;
            fcnt   <= '0;
            cur    <= BOOT_DEFAULT;
            rem    <= '0;
            waddr  <= '0;
            wbuf   <= '0;
            wbe    <= '0;
            rsp    <= RSP_OK;
            to_run <= 1'b0;
        end else begin
            unique case (state)
                LD_HOLD: if (mem_up) state <= PRELOADED ? LD_RUN : LD_OP;
                LD_OP: if (rx_take) begin
                    op   <= rx_data;
                    fcnt <= '0;
                    if (rx_data == OP_FILL || rx_data == OP_ZERO || rx_data == OP_START) begin
                        state <= LD_ADDR;
                    end else begin
                        rsp    <= RSP_BAD;
                        to_run <= 1'b0;
                        state  <= LD_RSP;
                    end
                end
                LD_ADDR: if (rx_take) begin
                    cur  <= addr_next;
                    fcnt <= fcnt + 1'b1;
                    if (fcnt == 2'd3) begin
                        if (op == OP_START) begin
                            rsp    <= RSP_OK;
                            to_run <= 1'b1;
                            state  <= LD_RSP;
                        end else begin
                            state <= LD_LEN;
                        end
                    end
                end
                LD_LEN: if (rx_take) begin
                    rem  <= len_next;
                    fcnt <= fcnt + 1'b1;
                    if (fcnt == 2'd3) begin
                        rsp    <= RSP_OK;
                        to_run <= 1'b0;
                        wbe    <= '0;
                        wbuf   <= '0;
                        if (len_next == 32'd0)    state <= LD_RSP;
                        else if (op == OP_FILL)   state <= LD_DATA;
                        else                      state <= LD_ZERO;
                    end
                end
                LD_DATA: if (rx_take) begin
                    wbuf[{lane, 3'b000} +: 8] <= rx_data;
                    wbe[lane]                 <= 1'b1;
                    cur                       <= cur + 32'd1;
                    rem                       <= rem - 32'd1;
                    if (lane == LW'(NB - 1) || rem == 32'd1) begin
                        waddr <= cur_word;
                        state <= LD_WR;
                    end
                end
                LD_WR: if (mem_ready) begin
                    wbe   <= '0;
                    wbuf  <= '0;
                    state <= (rem == 32'd0) ? LD_RSP : LD_DATA;
                end
                LD_ZERO: if (mem_ready) begin
                    cur <= cur + zero_n;
                    rem <= rem - zero_n;
                    if (rem == zero_n) state <= LD_RSP;
                end
                LD_RSP: if (tx_ready) state <= to_run ? LD_RUN : LD_OP;
                LD_RUN: state <= LD_RUN;
                default: state <= LD_HOLD;
            endcase
        end
    end

    // Port drive derived from the current state.
    always_comb begin
        rx_ready  = (state == LD_OP) || (state == LD_ADDR) || (state == LD_LEN) ||
                    (state == LD_DATA) || (state == LD_RUN);
        tx_valid  = (state == LD_RSP);
        tx_data   = rsp;
        mem_req   = (state == LD_WR) || (state == LD_ZERO);
        mem_addr  = (state == LD_ZERO) ? cur_word : waddr;
        mem_wdata = (state == LD_ZERO) ? '0 : wbuf;
        mem_be    = (state == LD_ZERO) ? zero_be : ((state == LD_WR) ? wbe : '0);
        boot_go   = ((state == LD_RSP) && tx_ready && to_run) ||
                    (PRELOADED && (state == LD_HOLD) && mem_up);
        go_addr   = cur;
    end

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || load_req)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_wdata) && $stable(mem_be)));
    // R13
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || load_req)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R5
    be_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != '0));
endmodule

// File: rtl/serial_boot_ctrl.sv
// Serial boot controller top: reset sequencer plus command parser/writer.
// Assumes a decoded UART byte stream and a single-beat memory write port.
module serial_boot_ctrl #(
    parameter int          DATA_W       = 32,
    parameter int          HOLD_CYC     = 4,
    parameter logic [31:0] BOOT_DEFAULT = 32'h0,
    parameter bit          PRELOADED    = 1'b0,
    localparam int         NB           = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NB-1:0]     mem_be,
    input  logic              mem_ready,
    output logic              mem_rst_n,
    output logic              core_rst_n,
    output logic [31:0]       boot_addr
);
    logic        mem_up;
    logic        boot_go;
    logic [31:0] go_addr;

    boot_rst_seq #(
        .HOLD_CYC     (HOLD_CYC),
        .BOOT_DEFAULT (BOOT_DEFAULT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .boot_go    (boot_go),
        .go_addr    (go_addr),
        .mem_rst_n  (mem_rst_n),
        .core_rst_n (core_rst_n),
        .mem_up     (mem_up),
        .boot_addr  (boot_addr)
    );

    boot_cmd_fsm #(
        .DATA_W       (DATA_W),
        .BOOT_DEFAULT (BOOT_DEFAULT),
        .PRELOADED    (PRELOADED)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .mem_up    (mem_up),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .mem_ready (mem_ready),
        .boot_go   (boot_go),
        .go_addr   (go_addr)
    );

    // R9
    port_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_rst_n && !core_rst_n));
endmodule

// File: tb/test_serial_boot_ctrl.sv
module test_serial_boot_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready;
    logic        mem_rst_n, core_rst_n;
    logic [31:0] boot_addr;
    logic        p_rx_ready, p_tx_valid, p_mem_req, p_mem_rst_n, p_core_rst_n;
    logic [7:0]  p_tx_data;
    logic [31:0] p_mem_addr, p_mem_wdata, p_boot_addr;
    logic [3:0]  p_mem_be;

    logic        stall_en = 1'b0;
    int          cyc = 0;
    int          beats = 0, gaps = 0, last_beat = -10, rsp_cnt = 0;
    logic [7:0]  last_rsp = 8'h00;
    logic [7:0]  mem_b [256] = '{default: 8'hAA};
    logic [7:0]  exp_b [256] = '{default: 8'hAA};
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    assign tx_ready  = 1'b1;
    assign mem_ready = !stall_en || cyc[0];

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_boot_ctrl #(.HOLD_CYC(HOLD)) i_serial_boot_ctrl (
        .clk(clk), .rst_n(rst_n), .load_req(load_req),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ready(mem_ready),
        .mem_rst_n(mem_rst_n), .core_rst_n(core_rst_n), .boot_addr(boot_addr)
    );

    // Second instance: image assumed preloaded (R12).
    serial_boot_ctrl #(.HOLD_CYC(HOLD), .PRELOADED(1'b1)) i_preloaded (
        .clk(clk), .rst_n(rst_n), .load_req(1'b0),
        .rx_data(rx_data), .rx_valid(1'b0), .rx_ready(p_rx_ready),
        .tx_data(p_tx_data), .tx_valid(p_tx_valid), .tx_ready(1'b1),
        .mem_req(p_mem_req), .mem_addr(p_mem_addr), .mem_wdata(p_mem_wdata),
        .mem_be(p_mem_be), .mem_ready(1'b1),
        .mem_rst_n(p_mem_rst_n), .core_rst_n(p_core_rst_n), .boot_addr(p_boot_addr)
    );

    // Memory model, beat/gap counting and answer capture.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem_b[int'({mem_addr[7:2], 2'b00}) + k] <= mem_wdata[8*k +: 8];
            beats     <= beats + 1;
            last_beat <= cyc;
            if (cyc != last_beat + 1) gaps <= gaps + 1;
        end
        if (tx_valid && tx_ready) begin
            rsp_cnt  <= rsp_cnt + 1;
            last_rsp <= tx_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_w32(input logic [31:0] w);
        for (int k = 0; k < 4; k++) send_byte(w[8*k +: 8]);
    endtask

    task automatic wait_rsp(input int base);
        for (int t = 0; t < 3000 && rsp_cnt == base; t++) @(negedge clk);
    endtask

    // Full command with expected-model update; returns the answer byte.
    task automatic do_cmd(input logic [7:0] op, input logic [31:0] a, input logic [31:0] n,
                          input logic [7:0] seed, output logic [7:0] rsp);
        int base = rsp_cnt;
        send_byte(op);
        if (op == 8'h01 || op == 8'h02 || op == 8'h03) send_w32(a);
        if (op == 8'h01 || op == 8'h02) send_w32(n);
        if (op == 8'h01)
            for (int i = 0; i < int'(n); i++) begin
                send_byte(seed + 8'(i));
                exp_b[(int'(a) + i) & 255] = seed + 8'(i);
            end
        if (op == 8'h02)
            for (int i = 0; i < int'(n); i++) exp_b[(int'(a) + i) & 255] = 8'h00;
        wait_rsp(base);
        rsp = last_rsp;
    endtask

    // {opcode, address, length, data seed, expected answer}
    localparam logic [87:0] VEC [8] = '{
        {8'h01, 32'h0000_0000, 32'd8,  8'h10, 8'h06},  // aligned fill (R4)
        {8'h01, 32'h0000_0010, 32'd6,  8'h40, 8'h06},  // trailing partial word (R5)
        {8'h01, 32'h0000_0021, 32'd5,  8'h70, 8'h06},  // unaligned start (R5)
        {8'h02, 32'h0000_0040, 32'd32, 8'h00, 8'h06},  // 8-word zero burst (R6)
        {8'h02, 32'h0000_0062, 32'd5,  8'h00, 8'h06},  // zero with partial ends (R6)
        {8'h09, 32'h0000_0000, 32'd0,  8'h00, 8'h15},  // unknown opcode (R7)
        {8'h01, 32'h0000_0080, 32'd0,  8'h00, 8'h06},  // zero length (R4)
        {8'h01, 32'h0000_0090, 32'd3,  8'hA0, 8'h06}   // short fill under stall (R13)
    };

    initial begin
        for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int b0, g0, c0, t0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mem_rst_n in reset", 32'(mem_rst_n), 32'd0);
        check("R1 core_rst_n in reset", 32'(core_rst_n), 32'd0);
        check("R1 boot_addr default", boot_addr, 32'h0);
        rst_n = 1'b1;
        t0 = 0;
        while (!mem_rst_n && t0 < 50) begin @(negedge clk); t0++; end
        // R2: hold length and core still held
        check("R2 hold cycles", 32'(t0), 32'(HOLD));
        check("R2 core held after memory release", 32'(core_rst_n), 32'd0);
        @(negedge clk);
        // R12: preloaded variant starts by itself
        check("R12 preloaded core released", 32'(p_core_rst_n), 32'd1);
        check("R12 preloaded boot address", p_boot_addr, 32'h0);

        for (int i = 0; i < 8; i++) begin
            stall_en = (i == 1 || i == 7);
            b0 = beats;
            g0 = gaps;
            do_cmd(VEC[i][87:80], VEC[i][79:48], VEC[i][47:16], VEC[i][15:8], r);
            check($sformatf("R7 answer of entry %0d", i), 32'(r), 32'(VEC[i][7:0]));
            check($sformatf("R3 core held after entry %0d", i), 32'(core_rst_n), 32'd0);
            if (i == 3) begin
                check("R6 zero burst beats", 32'(beats - b0), 32'd8);
                check("R6 zero burst gaps", 32'(gaps - g0), 32'd1);
            end
            if (i == 6) check("R4 zero length no write", 32'(beats - b0), 32'd0);
            stall_en = 1'b0;
        end
        @(negedge clk);
        // R4 R5 R6: memory image against the expected byte model
        for (int w = 0; w < 64; w++)
            check($sformatf("R4 R5 R6 memory word %0d", w),
                  {mem_b[4*w+3], mem_b[4*w+2], mem_b[4*w+1], mem_b[4*w]},
                  {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]});

        // R10: abort in the middle of a stalled zero burst
        stall_en = 1'b1;
        b0 = beats;
        send_byte(8'h02);
        send_w32(32'h0);
        send_w32(32'd200);
        while (beats - b0 < 3) @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        check("R10 mem_req dropped", 32'(mem_req), 32'd0);
        check("R10 memory reset asserted", 32'(mem_rst_n), 32'd0);
        check("R10 core reset asserted", 32'(core_rst_n), 32'd0);
        b0 = beats;
        repeat (10) @(negedge clk);
        check("R10 no writes after abort", 32'(beats - b0), 32'd0);
        stall_en = 1'b0;
        while (!mem_rst_n) @(negedge clk);
        do_cmd(8'h01, 32'h0000_00F0, 32'd4, 8'h55, r);
        check("R10 reload answer", 32'(r), 32'h06);
        @(negedge clk);
        check("R10 reload data", {mem_b[243], mem_b[242], mem_b[241], mem_b[240]}, 32'h5857_5655);

        // R8: start command
        do_cmd(8'h03, 32'h0000_0100, 32'd0, 8'h00, r);
        check("R8 start answer", 32'(r), 32'h06);
        check("R8 core released", 32'(core_rst_n), 32'd1);
        check("R8 boot address", boot_addr, 32'h0000_0100);
        // R9: bytes after start are dropped
        b0 = beats;
        c0 = rsp_cnt;
        send_byte(8'h01);
        send_w32(32'h0);
        send_w32(32'd4);
        send_w32(32'hDEAD_BEEF);
        repeat (20) @(negedge clk);
        check("R9 no writes after start", 32'(beats - b0), 32'd0);
        check("R9 no answers after start", 32'(rsp_cnt - c0), 32'd0);

        // R11: pushbutton restarts the sequence
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 core back in reset", 32'(core_rst_n), 32'd0);
        check("R11 memory back in reset", 32'(mem_rst_n), 32'd0);
        check("R11 boot address default", boot_addr, 32'h0);
        rst_n = 1'b1;
        while (!mem_rst_n) @(negedge clk);
        do_cmd(8'h07, 32'h0, 32'd0, 8'h00, r);
        check("R11 loader alive after restart", 32'(r), 32'h15);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule